// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Datapath

This block is a small synchronous memory whose address, controls and write data are all registered on the rising clock edge. A write commits to the array on the following edge, one 9-bit lane at a time, under strobes decoded from a whole-word write enable and a lane-write enable combined with per-lane selects. A read passes through two registers, an array read register and an output register. Its data reaches the output two edges after the address was captured.

The output side is meant for a bus shared with other devices. Three select inputs form one chip select. A read shows on the bus only if the device was still selected in the cycle after the read was captured. Selection therefore turns the drive on after two edges and turns it off after one, so a device handing the bus to a neighbour releases it before the neighbour starts driving. An output enable and a doze input mute the drive at once, without a clock edge. Doze also stops new reads and writes from taking effect. Each word holds four lanes of 8 data bits plus a parity bit. Burst addressing is generated outside the block.

Top module: `pipe_sram`

## Requirements
- R1: Address, controls and write data are captured at a rising edge. A write captured at edge N changes the array at edge N+1, with no other write pulse.
- R2: A read captured at edge N shows its word on `rdata` with `rdata_oe` high after edge N+2, provided `out_en_n` is low and `doze` is low. A read cycle is one that is selected, not dozing, and has both `wr_all_n` and `wr_lane_en_n` high.
- R3: With `wr_all_n` low in a selected cycle, all four lanes are written, whatever `wr_lane_en_n` and `lane_sel_n` hold.
- R4: With `wr_all_n` high and `wr_lane_en_n` low, lane i (bits 9i+8 down to 9i of the word) is written only when `lane_sel_n[i]` is low. The other lanes keep their contents.
- R5: A read captured at the edge right after a write to the same address returns the newly written lanes merged with the unwritten old lanes.
- R6: The device is selected when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. Output drive after edge E also needs the device to have been selected at edge E-1. A deselect captured at edge M therefore drops `rdata_oe` after edge M+1, and this also discards a read captured at M-1.
- R7: `rdata_oe` is low whenever `out_en_n` is high. The output follows `out_en_n` between clock edges.
- R8: While `doze` is high, `rdata_oe` is low at once. A selected cycle captured while dozing is neither a read nor a write, and a captured write does not commit at an edge where `doze` is high.
- R9: A selected write cycle (`wr_all_n` low or `wr_lane_en_n` low) never causes `rdata_oe` to go high, even when no lane is strobed.
- R10: Asserting `rst_n` low clears the pipeline at once, leaving `rdata_oe` low. The internal reset is released on the second rising edge after `rst_n` goes high. Reset does not clear the array.
- R11: `rdata` reads all zeros whenever `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_a_n | input | 1 | Chip select term, active low |
| sel_b | input | 1 | Chip select term, active high |
| sel_c_n | input | 1 | Chip select term, active low |
| addr | input | AW (4) | Word address |
| wr_all_n | input | 1 | Whole-word write, active low, overrides lane controls |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES (4) | Per-lane write select, active low |
| wdata | input | DW (36) | Write data, lane i at bits 9i+8:9i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Power-down, active high |
| rdata | output | DW (36) | Read data, zero when not driving |
| rdata_oe | output | 1 | Output drive enable |

## Verification
The assertions rely on the select, write and doze inputs being stable around each rising edge, and on `rst_n` being held low long enough for the internal reset to take hold before any read is issued. They also assume that words are read only after they have been written at least once, because the array has no reset. The bench changes every input only at falling edges. It fills the whole array with whole-word writes before any read, so each read returns a defined value. It toggles `out_en_n` and `doze` only between edges, where their effect is meant to be immediate.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  // Kind of access held in the capture stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // Number of flops in the reset release chain
  localparam int RST_STAGES = 2;

endpackage

// File: rtl/pipe_sram_rstsync.sv
module pipe_sram_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assert at once, release after STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pipe_sram_wdec.sv
module pipe_sram_wdec #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] strobe,
  output logic             is_write
);

  // Whole-word write wins over the lane path
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      strobe[g] = !wr_all_n || (!wr_lane_en_n && !lane_sel_n[g]);
    end
  end

  always_comb begin
    is_write = !wr_all_n || !wr_lane_en_n;
  end

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [AW-1:0]    acc_addr,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_strb,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data
);

  // One storage column per lane; contents are never reset
  for (genvar g = 0; g < LANES; g++) begin : g_col
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic [LANE_W-1:0] rd_d;
    logic              lane_wr;

    always_comb begin
      lane_wr = wr_en && wr_strb[g];
      rd_d    = rd_en ? cells[acc_addr] : rd_q;
    end

    always_ff @(posedge clk) begin
      if (lane_wr) cells[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      rd_q <= rd_d;
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/pipe_sram_outctl.sv
module pipe_sram_outctl #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          b_rd,
  input  logic          b_sel,
  input  logic [DW-1:0] b_data,
  input  logic          out_en_n,
  input  logic          doze,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);

  logic          c_rd_q, c_rd_d;
  logic [DW-1:0] c_data_q, c_data_d;
  logic          drive;

  always_comb begin
    c_rd_d   = b_rd;
    c_data_d = b_rd ? b_data : c_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_rd_q <= 1'b0;
    else        c_rd_q <= c_rd_d;
  end

  always_ff @(posedge clk) begin
    c_data_q <= c_data_d;
  end

  // Enable and doze act without a clock
  always_comb begin
    drive    = c_rd_q && b_sel && !out_en_n && !doze;
    rdata_oe = drive;
    rdata    = drive ? c_data_q : '0;
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [DW-1:0]    wdata,
  input  logic             out_en_n,
  input  logic             doze,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);

  logic rst_i_n;

  pipe_sram_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Lane strobe decode on the raw inputs
  logic [LANES-1:0] strb_now;
  logic             wr_now;

  pipe_sram_wdec #(.LANES(LANES)) u_wdec (
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .strobe       (strb_now),
    .is_write     (wr_now)
  );

  // Capture stage
  sram_op_e         a_op_q, a_op_d;
  logic             a_sel_q, a_sel_d;
  logic [AW-1:0]    a_addr_q, a_addr_d;
  logic [LANES-1:0] a_strb_q, a_strb_d;
  logic [DW-1:0]    a_wdata_q, a_wdata_d;
  logic             sel_now, cap_en;

  always_comb begin
    sel_now   = !sel_a_n && sel_b && !sel_c_n;
    cap_en    = sel_now && !doze;
    a_sel_d   = sel_now;
    a_op_d    = OP_IDLE;
    if (cap_en) a_op_d = wr_now ? OP_WRITE : OP_READ;
    a_addr_d  = cap_en ? addr : a_addr_q;
    a_strb_d  = (cap_en && wr_now) ? strb_now : a_strb_q;
    a_wdata_d = (cap_en && wr_now) ? wdata : a_wdata_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      a_op_q  <= OP_IDLE;
      a_sel_q <= 1'b0;
    end else begin
      a_op_q  <= a_op_d;
      a_sel_q <= a_sel_d;
    end
  end

  always_ff @(posedge clk) begin
    a_addr_q  <= a_addr_d;
    a_strb_q  <= a_strb_d;
    a_wdata_q <= a_wdata_d;
  end

  // Array access from the capture stage
  logic          arr_wr_en, arr_rd_en;
  logic [DW-1:0] arr_rd_data;

  always_comb begin
    arr_wr_en = (a_op_q == OP_WRITE) && !doze;
    arr_rd_en = (a_op_q == OP_READ);
  end

  pipe_sram_array #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .DEPTH  (DEPTH)
  ) u_array (
    .clk      (clk),
    .acc_addr (a_addr_q),
    .wr_en    (arr_wr_en),
    .wr_strb  (a_strb_q),
    .wr_data  (a_wdata_q),
    .rd_en    (arr_rd_en),
    .rd_data  (arr_rd_data)
  );

  // Array read stage control
  logic b_rd_q, b_rd_d;
  logic b_sel_q, b_sel_d;

  always_comb begin
    b_rd_d  = (a_op_q == OP_READ);
    b_sel_d = a_sel_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      b_rd_q  <= 1'b0;
      b_sel_q <= 1'b0;
    end else begin
      b_rd_q  <= b_rd_d;
      b_sel_q <= b_sel_d;
    end
  end

  pipe_sram_outctl #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .b_rd     (b_rd_q),
    .b_sel    (b_sel_q),
    .b_data   (arr_rd_data),
    .out_en_n (out_en_n),
    .doze     (doze),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          wr_all_n,
  input logic          wr_lane_en_n,
  input logic          out_en_n,
  input logic          doze,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe
);

  logic sel_req, rd_req, wr_req;

  always_comb begin
    sel_req = !sel_a_n && sel_b && !sel_c_n;
    rd_req  = sel_req && !doze && wr_all_n && wr_lane_en_n;
    wr_req  = sel_req && !doze && (!wr_all_n || !wr_lane_en_n);
  end

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !out_en_n);

  // R8
  doze_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> !rdata_oe);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  // R2
  read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(rd_req, 3));

  // R6
  sel_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(sel_req, 2));

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_req, 3) |-> !rdata_oe);

endmodule

bind pipe_sram pipe_sram_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_a_n      (sel_a_n),
  .sel_b        (sel_b),
  .sel_c_n      (sel_c_n),
  .wr_all_n     (wr_all_n),
  .wr_lane_en_n (wr_lane_en_n),
  .out_en_n     (out_en_n),
  .doze         (doze),
  .rdata        (rdata),
  .rdata_oe     (rdata_oe)
);

// File: tb/tb_pipe_sram.sv
module tb_pipe_sram;

  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int DW    = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic [DW-1:0] wdata = '0;
  logic out_en_n = 1'b0, doze = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  always #4 clk = ~clk;

  pipe_sram dut (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .out_en_n(out_en_n), .doze(doze),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int vectors = 0;
  int misses  = 0;
  string cur_req = "R10";

  // Reference state
  logic [DW-1:0] rmem [DEPTH];
  logic pa_rd = 0, pa_wr = 0, pa_sel = 0;
  logic [AW-1:0] pa_addr = '0;
  logic [LANES-1:0] pa_strb = '0;
  logic [DW-1:0] pa_wdata = '0;
  logic pb_rd = 0, pb_sel = 0, pc_rd = 0;
  logic [DW-1:0] pb_data = '0, pc_data = '0;

  task automatic check1(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic eoe;
    logic [DW-1:0] edata;
    eoe   = pc_rd && pb_sel && !out_en_n && !doze;
    edata = eoe ? pc_data : '0;
    check1(cur_req, {35'd0, rdata_oe}, {35'd0, eoe}, "rdata_oe");
    check1(eoe ? cur_req : "R11", rdata, edata, "rdata");
  endtask

  task automatic model_edge();
    logic [DW-1:0] nb;
    logic s, w;
    nb = pb_data;
    if (pa_rd) nb = rmem[pa_addr];
    if (pa_wr && !doze)
      for (int i = 0; i < LANES; i++)
        if (pa_strb[i]) rmem[pa_addr][i*LW +: LW] = pa_wdata[i*LW +: LW];
    pc_rd = pb_rd; pc_data = pb_data;
    pb_rd = pa_rd; pb_sel = pa_sel; pb_data = nb;
    s = !sel_a_n && sel_b && !sel_c_n;
    w = !wr_all_n || !wr_lane_en_n;
    pa_sel = s;
    pa_rd  = s && !doze && !w;
    pa_wr  = s && !doze && w;
    pa_addr = addr;
    pa_wdata = wdata;
    for (int i = 0; i < LANES; i++)
      pa_strb[i] = !wr_all_n || (!wr_lane_en_n && !lane_sel_n[i]);
  endtask

  // Staged next inputs, applied at the falling edge
  logic n_sel = 0, n_wall = 1, n_wlane = 1, n_oe = 0, n_doze = 0;
  logic [1:0] n_selpat = 0;
  logic [AW-1:0] n_addr = '0;
  logic [LANES-1:0] n_lanes = '1;
  logic [DW-1:0] n_wdata = '0;

  task automatic tick();
    @(negedge clk);
    if (n_sel) begin sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; end
    else begin
      sel_a_n = (n_selpat != 2'd1); sel_b = (n_selpat != 2'd2); sel_c_n = (n_selpat != 2'd3);
      if (n_selpat == 2'd0) sel_a_n = 1'b1;
    end
    addr = n_addr; wr_all_n = n_wall; wr_lane_en_n = n_wlane;
    lane_sel_n = n_lanes; wdata = n_wdata; out_en_n = n_oe; doze = n_doze;
    #1;
    compare();
    @(posedge clk);
    model_edge();
  endtask

  function automatic logic [DW-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  task automatic set_idle();
    n_sel = 0; n_selpat = 2'($urandom); n_wall = 1; n_wlane = 1; n_oe = 0; n_doze = 0;
  endtask
  task automatic set_read(input int a);
    n_sel = 1; n_wall = 1; n_wlane = 1; n_addr = AW'(a); n_oe = 0; n_doze = 0;
  endtask
  task automatic set_gwrite(input int a, input logic [DW-1:0] d);
    n_sel = 1; n_wall = 0; n_wlane = 1'($urandom); n_lanes = 4'($urandom);
    n_addr = AW'(a); n_wdata = d; n_oe = 0; n_doze = 0;
  endtask
  task automatic set_bwrite(input int a, input logic [DW-1:0] d, input logic [LANES-1:0] ln);
    n_sel = 1; n_wall = 1; n_wlane = 0; n_lanes = ln;
    n_addr = AW'(a); n_wdata = d; n_oe = 0; n_doze = 0;
  endtask

  initial begin
    #(200000 * 8);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) rmem[i] = '0;
    // R10: reset state
    cur_req = "R10";
    #2;
    check1("R10", {35'd0, rdata_oe}, 36'd0, "rdata_oe in reset");
    check1("R10", rdata, '0, "rdata in reset");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    set_idle();
    repeat (4) tick();

    // R3: fill the array with whole-word writes, lane controls random
    cur_req = "R3";
    for (int a = 0; a < DEPTH; a++) begin set_gwrite(a, rnd36()); tick(); end
    set_idle(); tick();

    // R2: back-to-back reads of every word
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) begin set_read(a); tick(); end
    set_idle(); repeat (3) tick();

    // R1: single write, reads before and after commit
    cur_req = "R1";
    set_read(5); tick();
    set_gwrite(5, rnd36()); tick();
    set_idle(); tick();
    set_read(5); tick();
    set_idle(); repeat (3) tick();

    // R4: lane writes with every lane mask
    cur_req = "R4";
    for (int m = 0; m < 16; m++) begin
      set_bwrite(m, rnd36(), 4'(m)); tick();
      set_read(m); tick();
      set_read((m + 1) % DEPTH); tick();
    end
    set_idle(); repeat (3) tick();

    // R5: read right after a write to the same word
    cur_req = "R5";
    for (int k = 0; k < 20; k++) begin
      int a;
      a = $urandom_range(0, DEPTH - 1);
      if (k % 2 == 0) set_gwrite(a, rnd36()); else set_bwrite(a, rnd36(), 4'($urandom));
      tick();
      set_read(a); tick();
    end
    set_idle(); repeat (3) tick();

    // R9: lane write with no lane strobed drives nothing
    cur_req = "R9";
    for (int k = 0; k < 6; k++) begin set_bwrite(k, rnd36(), 4'hF); tick(); end
    set_idle(); repeat (3) tick();

    // R6: read then deselect, and select toggling
    cur_req = "R6";
    for (int k = 0; k < 8; k++) begin
      set_read(k); tick();
      set_idle(); tick();
      set_read(k + 8); tick();
      set_read(k); tick();
      set_idle(); repeat (2) tick();
    end
    for (int k = 0; k < 120; k++) begin
      set_read($urandom_range(0, DEPTH - 1));
      if ($urandom_range(0, 2) == 0) begin n_sel = 0; n_selpat = 2'($urandom); end
      tick();
    end
    set_idle(); repeat (3) tick();

    // R7: output enable toggled between edges
    cur_req = "R7";
    for (int k = 0; k < 100; k++) begin
      set_read($urandom_range(0, DEPTH - 1));
      n_oe = ($urandom_range(0, 2) == 0);
      tick();
      // mid-cycle flip without a clock edge
      #1 out_en_n = ~out_en_n; #1;
      compare();
      out_en_n = ~out_en_n;
    end
    set_idle(); repeat (3) tick();

    // R8: doze blocks capture, commit and drive
    cur_req = "R8";
    for (int k = 0; k < 150; k++) begin
      int a;
      a = $urandom_range(0, DEPTH - 1);
      case ($urandom_range(0, 2))
        0: set_read(a);
        1: set_gwrite(a, rnd36());
        default: set_bwrite(a, rnd36(), 4'($urandom));
      endcase
      n_doze = ($urandom_range(0, 3) == 0);
      tick();
    end
    set_idle(); n_doze = 0; repeat (3) tick();
    for (int a = 0; a < DEPTH; a++) begin set_read(a); tick(); end
    set_idle(); repeat (3) tick();

    // R2: random mix of everything
    cur_req = "R2";
    for (int k = 0; k < 2000; k++) begin
      int a;
      a = $urandom_range(0, DEPTH - 1);
      case ($urandom_range(0, 4))
        0: set_gwrite(a, rnd36());
        1: set_bwrite(a, rnd36(), 4'($urandom));
        2: set_idle();
        default: set_read(a);
      endcase
      n_oe   = ($urandom_range(0, 9) == 0);
      n_doze = ($urandom_range(0, 19) == 0);
      tick();
    end

    // R10: asynchronous reset assertion clears drive at once
    cur_req = "R10";
    set_read(3); tick();
    set_read(4); tick();
    #1 rst_n = 1'b0; #1;
    check1("R10", {35'd0, rdata_oe}, 36'd0, "rdata_oe after async reset");
    check1("R10", rdata, '0, "rdata after async reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule